// File: doc/BRIEF.md
# Stereo Sample Attenuator and Output Router

This block sits between the serial audio receiver and the noise-shaping modulator. It takes a stereo pair of signed 18-bit samples with a valid strobe, scales each channel by a linear gain picked from an 8-bit code, and then builds each output channel from silence, the left sample, the right sample or the mono average. The gain codes are double-buffered, so a new gain for both channels can take effect on the same sample. A shared-gain control lets the left code drive both channels.

Soft mute lowers the gain in steps of one code per sample, and raises it the same way when released. An output-disable control and an infinite-zero detector both force the outputs to zero. The detector counts bit-clock ticks while the incoming data stays all-zero. Once the count reaches its limit it mutes the outputs, if detection is enabled, and raises a pull-low request for an external open-drain zero flag.

Top module: `atten_router`

## Requirements
- R1: A channel's gain is y/256, where y equals the 8-bit code c for c in 0..254 and y = 256 for c = 255. The scaled value is floor(sample*y/256), an arithmetic shift of the product, so code 0 gives 0 and code 255 passes the sample unchanged.
- R2: A pulse on `att_wr_i` stages `att_code_i` for the channel named by `att_sel_i` (0 left, 1 right). The applied codes change only on a write with `att_load_i` = 1, and that write loads both channels' staged codes, including the one written in that cycle. Both applied and staged codes reset to 255.
- R3: While `att_link_i` is 1, the applied left code scales both channels and the applied right code has no effect.
- R4: Each output has its own source select, with 2'b00 silence, 2'b01 the attenuated right sample, 2'b10 the attenuated left sample and 2'b11 the mono average. `route_l_i` drives the left output and `route_r_i` drives the right output.
- R5: The mono average is the 19-bit sign-extended sum of the two attenuated samples, shifted right arithmetically by one. It cannot overflow.
- R6: A mute level resets to 255. On each valid sample it drops by 1 while `soft_mute_i` is 1 and rises by 1 while it is 0, saturating at 0 and 255. A sample is scaled by min(applied code, level), where the level is the one held before that sample's update.
- R7: While `out_dis_i` is 1, both outputs read zero in the same cycle, whatever the data.
- R8: A counter advances on each `bck_tick_i` once an all-zero valid sample has been seen, saturating at ZERO_LIMIT (default 65,536). `zero_pull_o` is 1 exactly when `zdet_en_i` is 1 and the counter is at its limit, and both outputs read zero while it is 1.
- R9: A valid sample with either channel non-zero clears the counter and stops counting. `zero_pull_o` is 0 in the following cycle.
- R10: `out_valid_o` follows `smp_valid_i` one clock later. The processed pair registers on each valid sample and holds otherwise. After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_valid_i | input | 1 | Sample pair valid |
| smp_l_i | input | 18 | Left sample, two's complement |
| smp_r_i | input | 18 | Right sample, two's complement |
| bck_tick_i | input | 1 | One pulse per bit-clock cycle |
| att_wr_i | input | 1 | Gain code write strobe |
| att_sel_i | input | 1 | Write target: 0 left, 1 right |
| att_code_i | input | 8 | Gain code |
| att_load_i | input | 1 | Apply staged codes with this write |
| att_link_i | input | 1 | Left code scales both channels |
| route_l_i | input | 2 | Left output source |
| route_r_i | input | 2 | Right output source |
| soft_mute_i | input | 1 | Ramp gain down to silence |
| out_dis_i | input | 1 | Force outputs to zero |
| zdet_en_i | input | 1 | Enable infinite-zero muting |
| out_valid_o | output | 1 | Processed pair valid |
| out_l_o | output | 18 | Processed left sample |
| out_r_o | output | 18 | Processed right sample |
| zero_pull_o | output | 1 | Pull the open-drain zero flag low |

## Verification
The assertions check on every cycle that output-disable and the zero-flag pull both hold the outputs at zero, and that the pull never rises while detection is disabled. They also check that a non-zero sample drops the pull on the next cycle and that the valid output lags its input by one clock with the data held in between. The gain arithmetic, the 255-to-unity mapping, the double-buffered load, shared gain, the four source selections, the mono rounding and the shape of the soft-mute ramp all depend on sample values and history. Only the bench's reference model and directed scenarios can show these.

// File: rtl/atten_router_pkg.sv
package atten_router_pkg;
  typedef enum logic [1:0] {
    SRC_MUTE  = 2'b00,
    SRC_RIGHT = 2'b01,
    SRC_LEFT  = 2'b10,
    SRC_MONO  = 2'b11
  } src_sel_e;

  localparam int unsigned N_CH = 2;
endpackage

// File: rtl/ar_gain_ctrl.sv
module ar_gain_ctrl #(
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          sel_i,
  input  logic [CW-1:0] code_i,
  input  logic          load_i,
  input  logic          link_i,
  input  logic          smp_valid_i,
  input  logic          soft_mute_i,
  output logic [CW-1:0] eff_l_o,
  output logic [CW-1:0] eff_r_o
);
  localparam logic [CW-1:0] CODE_MAX = {CW{1'b1}};

  logic [CW-1:0] stg_q [2];
  logic [CW-1:0] app_q [2];
  logic [CW-1:0] lvl_q;

  for (genvar ch = 0; ch < 2; ch++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stg_q[ch] <= CODE_MAX;
        app_q[ch] <= CODE_MAX;
      end else if (wr_i) begin
        if (sel_i == 1'(ch)) stg_q[ch] <= code_i;
        // load applies both staged codes, the one written now included
        if (load_i) app_q[ch] <= (sel_i == 1'(ch)) ? code_i : stg_q[ch];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= CODE_MAX;
    else if (smp_valid_i) begin
      if (soft_mute_i && lvl_q != '0)             lvl_q <= lvl_q - 1'b1;
      else if (!soft_mute_i && lvl_q != CODE_MAX) lvl_q <= lvl_q + 1'b1;
    end
  end

  logic [CW-1:0] r_sel;
  assign r_sel   = link_i ? app_q[0] : app_q[1];
  assign eff_l_o = (app_q[0] < lvl_q) ? app_q[0] : lvl_q;
  assign eff_r_o = (r_sel < lvl_q) ? r_sel : lvl_q;
endmodule

// File: rtl/ar_scale.sv
module ar_scale #(
  parameter int unsigned DW = 18,
  parameter int unsigned CW = 8
) (
  input  logic signed [DW-1:0] smp_i,
  input  logic        [CW-1:0] code_i,
  output logic signed [DW-1:0] res_o
);
  localparam int unsigned GW = CW + 1;
  localparam int unsigned PW = DW + GW + 1;

  logic [GW-1:0]        gain;
  logic signed [PW-1:0] a_ext, b_ext, prod;
  logic                 unused_bits;

  // all-ones code maps to exact unity
  assign gain  = (&code_i) ? {1'b1, {CW{1'b0}}} : {1'b0, code_i};
  assign a_ext = PW'(smp_i);
  assign b_ext = PW'($signed({1'b0, gain}));
  assign prod  = a_ext * b_ext;
  assign res_o = prod[CW +: DW];
  assign unused_bits = ^{prod[CW-1:0], prod[PW-1:CW+DW]};
endmodule

// File: rtl/ar_route.sv
module ar_route
  import atten_router_pkg::*;
#(
  parameter int unsigned DW = 18
) (
  input  logic        [1:0]    sel_i,
  input  logic signed [DW-1:0] l_i,
  input  logic signed [DW-1:0] r_i,
  output logic signed [DW-1:0] o
);
  logic signed [DW:0] sum;
  logic               unused_lsb;

  assign sum        = {l_i[DW-1], l_i} + {r_i[DW-1], r_i};
  assign unused_lsb = sum[0];

  always_comb begin
    unique case (src_sel_e'(sel_i))
      SRC_RIGHT: o = r_i;
      SRC_LEFT:  o = l_i;
      SRC_MONO:  o = sum[DW:1];
      default:   o = '0;
    endcase
  end
endmodule

// File: rtl/ar_zero_watch.sv
module ar_zero_watch #(
  parameter int unsigned DW         = 18,
  parameter int unsigned ZERO_LIMIT = 65536
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          smp_valid_i,
  input  logic [DW-1:0] smp_l_i,
  input  logic [DW-1:0] smp_r_i,
  input  logic          tick_i,
  input  logic          en_i,
  output logic          pull_o
);
  localparam int unsigned CNTW = $clog2(ZERO_LIMIT + 1);
  localparam logic [CNTW-1:0] TERM = CNTW'(ZERO_LIMIT);

  logic [CNTW-1:0] cnt_q;
  logic            seen_q;
  logic            nz;

  assign nz = (smp_l_i != '0) || (smp_r_i != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else if (smp_valid_i && nz) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      if (smp_valid_i) seen_q <= 1'b1;
      if (tick_i && seen_q && cnt_q != TERM) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign pull_o = en_i && (cnt_q == TERM);
endmodule

// File: rtl/atten_router.sv
module atten_router
  import atten_router_pkg::*;
#(
  parameter int unsigned DW         = 18,
  parameter int unsigned CW         = 8,
  parameter int unsigned ZERO_LIMIT = 65536
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 smp_valid_i,
  input  logic signed [DW-1:0] smp_l_i,
  input  logic signed [DW-1:0] smp_r_i,
  input  logic                 bck_tick_i,
  input  logic                 att_wr_i,
  input  logic                 att_sel_i,
  input  logic        [CW-1:0] att_code_i,
  input  logic                 att_load_i,
  input  logic                 att_link_i,
  input  logic        [1:0]    route_l_i,
  input  logic        [1:0]    route_r_i,
  input  logic                 soft_mute_i,
  input  logic                 out_dis_i,
  input  logic                 zdet_en_i,
  output logic                 out_valid_o,
  output logic signed [DW-1:0] out_l_o,
  output logic signed [DW-1:0] out_r_o,
  output logic                 zero_pull_o
);
  logic        [CW-1:0] code_a [N_CH];
  logic signed [DW-1:0] in_a   [N_CH];
  logic signed [DW-1:0] att_a  [N_CH];
  logic signed [DW-1:0] rt_a   [N_CH];
  logic signed [DW-1:0] out_q  [N_CH];
  logic        [1:0]    sel_a  [N_CH];
  logic                 vld_q, force_zero;

  assign in_a[0]  = smp_l_i;
  assign in_a[1]  = smp_r_i;
  assign sel_a[0] = route_l_i;
  assign sel_a[1] = route_r_i;

  ar_gain_ctrl #(.CW(CW)) u_gain (
    .clk_i, .rst_ni,
    .wr_i(att_wr_i), .sel_i(att_sel_i), .code_i(att_code_i),
    .load_i(att_load_i), .link_i(att_link_i),
    .smp_valid_i, .soft_mute_i,
    .eff_l_o(code_a[0]), .eff_r_o(code_a[1])
  );

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    ar_scale #(.DW(DW), .CW(CW)) u_scale (
      .smp_i(in_a[ch]), .code_i(code_a[ch]), .res_o(att_a[ch])
    );
    ar_route #(.DW(DW)) u_route (
      .sel_i(sel_a[ch]), .l_i(att_a[0]), .r_i(att_a[1]), .o(rt_a[ch])
    );
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          out_q[ch] <= '0;
      else if (smp_valid_i) out_q[ch] <= rt_a[ch];
    end
  end

  ar_zero_watch #(.DW(DW), .ZERO_LIMIT(ZERO_LIMIT)) u_zero (
    .clk_i, .rst_ni, .smp_valid_i,
    .smp_l_i(smp_l_i), .smp_r_i(smp_r_i),
    .tick_i(bck_tick_i), .en_i(zdet_en_i), .pull_o(zero_pull_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= 1'b0;
    else         vld_q <= smp_valid_i;
  end

  assign force_zero  = out_dis_i || zero_pull_o;
  assign out_valid_o = vld_q;
  assign out_l_o     = force_zero ? '0 : out_q[0];
  assign out_r_o     = force_zero ? '0 : out_q[1];
endmodule

// File: rtl/atten_router_chk.sv
module atten_router_chk #(
  parameter int unsigned DW = 18
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          smp_valid_i,
  input logic [DW-1:0] smp_l_i,
  input logic [DW-1:0] smp_r_i,
  input logic          out_dis_i,
  input logic          zdet_en_i,
  input logic          out_valid_o,
  input logic [DW-1:0] out_l_o,
  input logic [DW-1:0] out_r_o,
  input logic          zero_pull_o
);
  p_dis_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_dis_i |-> (out_l_o == '0 && out_r_o == '0));

  p_pull_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_pull_o |-> (out_l_o == '0 && out_r_o == '0));

  p_pull_needs_en_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !zdet_en_i |-> !zero_pull_o);

  p_nonzero_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_i && (smp_l_i != '0 || smp_r_i != '0)) |=> !zero_pull_o);

  p_valid_rise_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_valid_i |=> out_valid_o);

  p_valid_fall_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_valid_i |=> !out_valid_o);

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!out_valid_o && !out_dis_i && !zero_pull_o && !$past(out_dis_i) && !$past(zero_pull_o))
      |-> ($stable(out_l_o) && $stable(out_r_o)));
endmodule

bind atten_router atten_router_chk #(.DW(DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .smp_valid_i(smp_valid_i),
  .smp_l_i(smp_l_i), .smp_r_i(smp_r_i), .out_dis_i(out_dis_i),
  .zdet_en_i(zdet_en_i), .out_valid_o(out_valid_o), .out_l_o(out_l_o),
  .out_r_o(out_r_o), .zero_pull_o(zero_pull_o)
);

// File: tb/atten_router_tb.sv
`timescale 1ns/1ps
module atten_router_tb;
  localparam int LIM = 64;

  logic clk = 0, rst_n = 0;
  logic vld = 0, tick = 0, wr = 0, wsel = 0, wload = 0, link = 0;
  logic smute = 0, dis = 0, zen = 0;
  logic signed [17:0] sl = 0, sr = 0;
  logic [7:0] wcode = 0;
  logic [1:0] rl = 2'b10, rr = 2'b01;
  wire        ov, pull;
  wire signed [17:0] ol, orr;

  int total = 0, fails = 0;
  bit done = 0;
  string tag = "R10";

  always #10 clk = ~clk;

  atten_router #(.ZERO_LIMIT(LIM)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .smp_valid_i(vld), .smp_l_i(sl), .smp_r_i(sr),
    .bck_tick_i(tick), .att_wr_i(wr), .att_sel_i(wsel), .att_code_i(wcode),
    .att_load_i(wload), .att_link_i(link), .route_l_i(rl), .route_r_i(rr),
    .soft_mute_i(smute), .out_dis_i(dis), .zdet_en_i(zen),
    .out_valid_o(ov), .out_l_o(ol), .out_r_o(orr), .zero_pull_o(pull)
  );

  // behavioural reference model
  int app[2], stg[2], lvl, cnt, mq[2];
  bit seen, mv;

  function automatic int gscale(int s, int c);
    longint p = longint'(s) * ((c == 255) ? 256 : c);
    return int'(p >>> 8);
  endfunction

  function automatic int pick(int sel, int a, int b);
    case (sel)
      1: return b;
      2: return a;
      3: return (a + b) >>> 1;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      app = '{255, 255}; stg = '{255, 255}; lvl = 255; cnt = 0;
      mq = '{0, 0}; seen = 0; mv = 0;
    end else begin
      int el, er, a0, a1;
      bit old_seen;
      el = (app[0] < lvl) ? app[0] : lvl;
      er = link ? app[0] : app[1];
      er = (er < lvl) ? er : lvl;
      if (vld) begin
        a0 = gscale(int'(sl), el);
        a1 = gscale(int'(sr), er);
        mq[0] = pick(int'(rl), a0, a1);
        mq[1] = pick(int'(rr), a0, a1);
      end
      mv = vld;
      old_seen = seen;
      if (vld && (sl != 0 || sr != 0)) begin
        cnt = 0; seen = 0;
      end else begin
        if (vld) seen = 1;
        if (tick && old_seen && cnt < LIM) cnt++;
      end
      if (vld) lvl = smute ? ((lvl > 0) ? lvl - 1 : 0) : ((lvl < 255) ? lvl + 1 : 255);
      if (wr) begin
        stg[wsel] = int'(wcode);
        if (wload) app = stg;
      end
    end
  end

  task automatic chk(string t, int got, int exp);
    total++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d at %0t", t, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit zp;
      zp = zen && (cnt == LIM);
      chk({tag, " pull"}, int'(pull), int'(zp));
      chk({tag, " valid"}, int'(ov), int'(mv));
      chk({tag, " left"}, int'(ol), (dis || zp) ? 0 : mq[0]);
      chk({tag, " right"}, int'(orr), (dis || zp) ? 0 : mq[1]);
    end
  end

  task automatic step();
    @(negedge clk); #2;
  endtask

  task automatic send(int l, int r);
    step(); vld = 1; sl = 18'(l); sr = 18'(r);
    step(); vld = 0;
  endtask

  task automatic wcode_put(bit s, int c, bit ld);
    step(); wr = 1; wsel = s; wcode = 8'(c); wload = ld;
    step(); wr = 0; wload = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: got hang expected finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk("R10 reset valid", int'(ov), 0);
    chk("R10 reset left", int'(ol), 0);
    chk("R10 reset pull", int'(pull), 0);
    rst_n = 1;

    tag = "R1";
    send(1000, -1000);
    chk("R1 unity left", int'(ol), 1000);
    chk("R1 unity right", int'(orr), -1000);
    wcode_put(0, 128, 1);
    send(1000, -1000);
    chk("R1 half left", int'(ol), 500);
    chk("R1 right kept", int'(orr), -1000);
    wcode_put(1, 1, 1);
    send(131071, -3);
    chk("R1 floor left", int'(ol), 65535);
    chk("R1 code1 neg floor", int'(orr), -1);
    wcode_put(0, 0, 1);
    send(1000, 131071);
    chk("R1 code0 silent", int'(ol), 0);
    chk("R1 code1 max", int'(orr), 511);

    tag = "R2";
    wcode_put(0, 10, 0);
    send(256, 256);
    chk("R2 staged not applied", int'(ol), 0);
    wcode_put(1, 20, 1);
    send(256, 256);
    chk("R2 load left", int'(ol), 10);
    chk("R2 load right", int'(orr), 20);

    tag = "R3";
    link = 1;
    send(256, 512);
    chk("R3 shared right", int'(orr), 20);
    chk("R3 shared left", int'(ol), 10);
    link = 0;

    tag = "R4";
    wcode_put(0, 255, 0);
    wcode_put(1, 255, 1);
    rl = 2'b00; rr = 2'b11;
    send(5, -2);
    chk("R4 mute src", int'(ol), 0);
    chk("R5 mono pos", int'(orr), 1);
    rl = 2'b01; rr = 2'b10;
    send(7, 9);
    chk("R4 swap left", int'(ol), 9);
    chk("R4 swap right", int'(orr), 7);
    tag = "R5";
    rl = 2'b11; rr = 2'b11;
    send(-5, 2);
    chk("R5 mono neg", int'(ol), -2);
    send(131071, 131071);
    chk("R5 mono no overflow", int'(orr), 131071);
    rl = 2'b10; rr = 2'b01;

    tag = "R6";
    smute = 1;
    for (int i = 0; i < 260; i++) send(131071, 131071);
    chk("R6 ramp reaches zero", int'(ol), 0);
    smute = 0;
    send(131071, 131071);
    chk("R6 first up uses zero", int'(ol), 0);
    send(131071, 131071);
    chk("R6 one step up", int'(ol), 511);
    for (int i = 0; i < 260; i++) send(131071, -131072);
    chk("R6 recovered left", int'(ol), 131071);
    chk("R6 recovered right", int'(orr), -131072);

    tag = "R7";
    step(); dis = 1; #1;
    chk("R7 disable left", int'(ol), 0);
    chk("R7 disable right", int'(orr), 0);
    step(); dis = 0; #1;
    chk("R7 release", int'(ol), 131071);

    tag = "R8";
    zen = 1; tick = 1;
    send(0, 0);
    repeat (30) step();
    chk("R8 below limit", int'(pull), 0);
    repeat (40) step();
    chk("R8 pull at limit", int'(pull), 1);
    zen = 0; #1;
    chk("R8 disabled no pull", int'(pull), 0);
    zen = 1; #1;
    chk("R8 re-enabled pull", int'(pull), 1);

    tag = "R9";
    send(4, 0);
    chk("R9 pull cleared", int'(pull), 0);
    chk("R9 data through", int'(ol), 4);
    tick = 0; zen = 0;
    repeat (3) step();

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule